// File: doc/BRIEF.md
# Four-beat burst address sequencer

The sequencer turns one presented address into the four addresses of a memory burst. A load captures the full input address. After a load, the low two bits of the internal address move through the other three beats of the aligned group of four, one beat per clock while the advance input is low. The upper bits stay at the value captured by the load.

Two active-low strobes can start a load. The controller-side strobe always loads. The processor-side strobe loads only while the active-low chip enable is asserted. The order select input picks one of two beat orders. Linear order adds the beat count to the start position, modulo four. Interleaved order XORs the start position with the beat count.

The order select input is a static strap. The internal address comes straight from registers, so it changes only at a clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with no load, `addr_out` is zero.
- R2: When `ctl_strobe_n` is 0 at a rising edge, `addr_out` equals the `addr_in` sampled at that edge. This holds whatever the values of `ce_n`, `cpu_strobe_n` and `adv_n`.
- R3: When `cpu_strobe_n` is 0 and `ce_n` is 0 at an edge, a load happens as in R2. When `ce_n` is 1, `cpu_strobe_n` has no effect on `addr_out`.
- R4: With no load and `adv_n` = 0 at an edge, the beat count rises by one, so the low two bits of `addr_out` move to the next beat.
- R5: With no load and `adv_n` = 1 at an edge, `addr_out` keeps its value.
- R6: With `order_sel` = 0 (linear), the low two bits equal (start + count) mod 4. Starting at 2, the beats are 2, 3, 0, 1.
- R7: With `order_sel` = 1 (interleaved), the low two bits equal start XOR count. Starting at 1, the beats are 1, 0, 3, 2.
- R8: Bits above bit 1 of `addr_out` change only on a load, and then take the loaded value.
- R9: A load wins over an advance in the same cycle. It restarts the sequence at count 0 from the new address.
- R10: An advance after the fourth beat wraps the count back to 0, which returns the low bits to the start beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | AW | Address presented for a load |
| cpu_strobe_n | input | 1 | Processor-side load strobe, active low, qualified by `ce_n` |
| ctl_strobe_n | input | 1 | Controller-side load strobe, active low, not qualified |
| ce_n | input | 1 | Active-low chip enable that gates `cpu_strobe_n` |
| adv_n | input | 1 | Active-low burst advance |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_out | output | AW | Internal burst address |

## Verification
The hardest case to reach from the ports is a load that arrives in the middle of a burst, in the same cycle as an advance request. A second hard case is an advance past the fourth beat, because it exposes the count wrapping and not the address.

Directed sequences create both cases in linear order and in interleaved order, from start positions that are not zero. A long run with mixed stimulus then biases the strobes to be rare, so bursts run past four beats. A behavioural model built from integer arithmetic predicts every cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } beat_order_e;

    // Position within the aligned group for a given start and beat count.
    function automatic logic [1:0] beat_pos(input logic [1:0] start,
                                            input logic [1:0] count,
                                            input beat_order_e order);
        if (order == ORDER_INTERLEAVED)
            return start ^ count;
        else
            return start + count;
    endfunction

endpackage

// File: rtl/burst_seq_gate.sv
module burst_seq_gate (
    input  logic cpu_strobe_n,
    input  logic ctl_strobe_n,
    input  logic ce_n,
    input  logic adv_n,
    output logic load,
    output logic advance
);
    // Controller strobe is unconditional; processor strobe needs chip enable.
    assign load    = ~ctl_strobe_n | (~cpu_strobe_n & ~ce_n);
    assign advance = ~adv_n;
endmodule

// File: rtl/burst_seq_state.sv
module burst_seq_state #(
    parameter int AW = 20,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] base,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] count;
    } seq_state_t;

    seq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.base  = addr_in;
            state_d.count = '0;
        end else if (advance) begin
            state_d.count = state_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign base  = state_q.base;
    assign count = state_q.count;
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map #(
    parameter int AW = 20,
    parameter int CW = 2
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  logic          order_sel,
    output logic [AW-1:0] addr_out
);
    import burst_seq_pkg::*;

    logic [CW-1:0] low;

    always_comb begin
        low = beat_pos(base[CW-1:0], count, beat_order_e'(order_sel));
    end

    assign addr_out = {base[AW-1:CW], low};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int AW    = 20,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          cpu_strobe_n,
    input  logic          ctl_strobe_n,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          order_sel,
    output logic [AW-1:0] addr_out
);
    localparam int CW = $clog2(BEATS);

    logic          load, advance;
    logic [AW-1:0] base;
    logic [CW-1:0] count;

    burst_seq_gate u_gate (
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .ce_n         (ce_n),
        .adv_n        (adv_n),
        .load         (load),
        .advance      (advance)
    );

    burst_seq_state #(.AW(AW), .CW(CW)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .addr_in (addr_in),
        .base    (base),
        .count   (count)
    );

    burst_seq_map #(.AW(AW), .CW(CW)) u_map (
        .base      (base),
        .count     (count),
        .order_sel (order_sel),
        .addr_out  (addr_out)
    );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int AW = 20,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_in,
    input logic          cpu_strobe_n,
    input logic          ctl_strobe_n,
    input logic          ce_n,
    input logic          adv_n,
    input logic          order_sel,
    input logic [AW-1:0] addr_out
);
    logic any_load;
    assign any_load = !ctl_strobe_n || (!cpu_strobe_n && !ce_n);

    always_comb begin
        if (!rst_n) assert_reset_zero_R1: assert (addr_out == '0);
    end

    assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_strobe_n |=> addr_out == $past(addr_in));

    assert_cpu_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && !ce_n) |=> addr_out == $past(addr_in));

    assert_cpu_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_strobe_n && !cpu_strobe_n && ce_n && adv_n) |=> $stable(addr_out));

    assert_advance_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_load && !adv_n) |=> addr_out[CW-1:0] != $past(addr_out[CW-1:0]));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_load && adv_n) |=> $stable(addr_out));

    assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_load && !adv_n && !order_sel && $stable(order_sel))
        |=> addr_out[CW-1:0] == $past(addr_out[CW-1:0]) + 1'b1);

    assert_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_load |=> addr_out[AW-1:CW] == $past(addr_out[AW-1:CW]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_in      (addr_in),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .ce_n         (ce_n),
    .adv_n        (adv_n),
    .order_sel    (order_sel),
    .addr_out     (addr_out)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          cpu_strobe_n = 1'b1;
    logic          ctl_strobe_n = 1'b1;
    logic          ce_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_out;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference state: loaded address and beat number as plain integers.
    int ref_base = 0;
    int ref_beat = 0;

    always #2 clk = ~clk;

    burst_addr_seq u_burst_addr_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_in      (addr_in),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .ce_n         (ce_n),
        .adv_n        (adv_n),
        .order_sel    (order_sel),
        .addr_out     (addr_out)
    );

    function automatic logic [AW-1:0] expected();
        int start, low;
        start = ref_base % 4;
        if (order_sel) low = start ^ ref_beat;
        else           low = (start + ref_beat) % 4;
        return AW'((ref_base / 4) * 4 + low);
    endfunction

    task automatic check(input string tag);
        logic [AW-1:0] exp_v;
        exp_v = expected();
        vectors++;
        if (addr_out !== exp_v) begin
            fails++;
            $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, exp_v);
        end
    endtask

    // Apply one cycle: inputs set away from the edge, model updated at the edge,
    // output compared 1 ns after the edge.
    task automatic cycle(input logic ctl_n, input logic cpu_n, input logic ce,
                         input logic adv, input logic [AW-1:0] a, input string tag);
        ctl_strobe_n = ctl_n;
        cpu_strobe_n = cpu_n;
        ce_n         = ce;
        adv_n        = adv;
        addr_in      = a;
        @(posedge clk);
        if (!ctl_n || (!cpu_n && !ce)) begin
            ref_base = int'(a);
            ref_beat = 0;
        end else if (!adv) begin
            ref_beat = (ref_beat + 1) % 4;
        end
        #1;
        check(tag);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        cycle(1, 1, 1, 1, 20'hABCDE, "R1 idle after reset");

        // Linear burst from start 2: 2,3,0,1 then wrap to 2.
        order_sel = 1'b0;
        cycle(0, 1, 1, 1, 20'h12346, "R2 ctl load with ce_n high");
        for (int i = 0; i < 5; i++) cycle(1, 1, 1, 0, 20'h0, "R4 R6 R10 linear beat");
        cycle(1, 1, 1, 1, 20'hFFFFF, "R5 hold");
        cycle(1, 1, 1, 1, 20'h00000, "R5 hold again");

        // Processor strobe gating.
        cycle(1, 0, 1, 1, 20'h55555, "R3 cpu strobe ignored while ce_n high");
        cycle(1, 0, 0, 1, 20'h55555, "R3 cpu strobe loads with ce_n low");

        // Interleaved from start 1: 1,0,3,2 then back to 1.
        order_sel = 1'b1;
        cycle(1, 0, 0, 1, 20'h0A0A1, "R3 load for interleaved burst");
        for (int i = 0; i < 4; i++) cycle(1, 1, 1, 0, 20'h0, "R4 R7 R10 interleaved beat");
        cycle(1, 1, 1, 0, 20'h0, "R8 upper bits kept");

        // Load in the middle of a burst, with advance also requested.
        cycle(1, 1, 1, 0, 20'h0, "R9 mid burst");
        cycle(0, 1, 1, 0, 20'h3C3C3, "R9 load wins over advance");
        cycle(1, 1, 1, 0, 20'h0, "R9 R7 restart beat");
        order_sel = 1'b0;
        cycle(1, 0, 0, 0, 20'h7777E, "R9 cpu load mid burst");
        cycle(1, 1, 1, 0, 20'h0, "R9 R6 restart beat");

        // Mixed stimulus in both orders, strobes kept rare.
        for (int phase = 0; phase < 2; phase++) begin
            order_sel = phase[0];
            cycle(0, 1, 1, 1, AW'($urandom), "R2 phase load");
            for (int i = 0; i < 300; i++) begin
                logic ctl_r, cpu_r, ce_r, adv_r;
                ctl_r = ($urandom % 10) != 0;
                cpu_r = ($urandom % 6) != 0;
                ce_r  = $urandom % 2;
                adv_r = ($urandom % 4) == 0;
                cycle(ctl_r, cpu_r, ce_r, adv_r, AW'($urandom), "R8 mixed");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule